// File: doc/BRIEF.md
# Two-Channel DMA Request Arbiter

This block decides who owns the system bus: the CPU or one of two DMA channels. Each channel holds one pending-request flag. A per-channel select input chooses where that flag is set from. It can come from a one-cycle internal request pulse. It can also come from the falling edge of an external interrupt pin, which is first passed through a flop synchronizer. When a channel is enabled and pending, a bus-ownership sequencer grants the bus to it. The sequencer clears the flag on the same clock edge and waits for a done strobe from the transfer engine.

Between two DMA transfers the bus always goes back to the CPU, and the CPU completes one access before the next channel is considered. This holds even when the other channel is already waiting. When both channels are eligible, channel 0 wins. Address generation, counting and data movement sit outside the block. A transfer appears here only as the interval between a grant and its done strobe.

Top module: `dma_req_arbiter`

## Requirements
- R1: With the internal source selected, a request pulse sets the channel's pending flag on the next rising clock edge. With the pin source selected, a high-to-low transition of the pin sets the flag on the third rising edge after the low level is applied (two synchronizer flops plus the edge detector). A pin held low, or a low-to-high transition, never sets it again.
- R2: A channel's pending flag clears on the same edge that its grant is raised.
- R3: Requests for both channels that arrive in the same cycle set both pending flags on the same edge.
- R4: When both channels are enabled and pending while the bus is free, channel 0 is granted first.
- R5: The cycle after a done strobe during a DMA transfer, the CPU holds the grant.
- R6: After a DMA transfer, no DMA grant is raised until the CPU signals the end of one bus access (cpu_done). Arbitration takes place on the following edge.
- R7: A channel whose enable input is 0 is never granted. Its pending flag stays set until the channel is enabled and served.
- R8: Exactly one of gnt_cpu, gnt_dma0 and gnt_dma1 is high in every cycle. The CPU holds the grant whenever no DMA transfer is active.
- R9: A request that arrives for a channel during that channel's own transfer sets its flag, and the channel is served again later.
- R10: Asserting rst_n low immediately clears both pending flags and gives the bus to the CPU. Release is synchronized to the clock and takes two edges.
- R11: For each channel, ext_sel=1 selects the pin source and ext_sel=0 selects the internal pulse. The source that is not selected has no effect on the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | 2 | Per-channel enable (bit 0 = channel 0) |
| ext_sel | input | 2 | Per-channel source select, 1 = pin falling edge, 0 = internal pulse |
| int_req | input | 2 | Per-channel internal one-cycle request pulse |
| ext_pin | input | 2 | Per-channel external interrupt pin, idle high |
| xfer_done | input | 1 | Strobe from the transfer engine ending the active DMA transfer |
| cpu_done | input | 1 | Strobe from the CPU ending one bus access |
| gnt_cpu | output | 1 | CPU owns the bus |
| gnt_dma0 | output | 1 | Channel 0 owns the bus |
| gnt_dma1 | output | 1 | Channel 1 owns the bus |
| req_pend | output | 2 | Pending-request flags (bit 0 = channel 0) |

## Verification
The bench raises both requests in the same cycle. A design that staggered the flags, or that served channel 1 first, would show the wrong flag pattern or the wrong grant. With channel 1 still pending after channel 0's transfer, the bench holds cpu_done low for extra cycles. A design that skipped the CPU slot would raise gnt_dma1 too early. The bench also re-requests a channel during its own transfer, where a clear that overrides a set would lose the request. It holds a pin low and then releases it high, where a level-sensitive or either-edge detector would fire more than once. Finally it drives the source that is not selected, and it asserts reset in the middle of a transfer.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [1:0] {
    ST_BUS_FREE = 2'd0,
    ST_BUS_OWED = 2'd1,
    ST_XFER0    = 2'd2,
    ST_XFER1    = 2'd3
  } bus_state_t;

endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/dma_req_capture.sv
module dma_req_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic use_ext,
  input  logic int_pulse,
  input  logic pin,
  input  logic grant_start,
  output logic req_o
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   pin_prev_q;
  logic                   req_q, req_d;
  logic                   pin_fall;
  logic                   set_req;

  // Synchronizer chain and edge detector; idle level of the pin is high.
  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= '1;
      pin_prev_q <= 1'b1;
    end else begin
      sync_q     <= sync_d;
      pin_prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign pin_fall = pin_prev_q & ~sync_q[SYNC_STAGES-1];
  assign set_req  = use_ext ? pin_fall : int_pulse;

  // A set in the same cycle as the start clear wins, so no request is lost.
  always_comb begin
    req_d = req_q;
    if (grant_start) req_d = 1'b0;
    if (set_req)     req_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign req_o = req_q;

  // R1
  req_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> req_q);

  // R2
  req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_start && !set_req) |=> !req_q);

endmodule

// File: rtl/dma_bus_sequencer.sv
module dma_bus_sequencer
  import dma_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] eligible,
  input  logic       xfer_done,
  input  logic       cpu_done,
  output logic [1:0] start,
  output logic       gnt_cpu,
  output logic       gnt_dma0,
  output logic       gnt_dma1
);

  bus_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    start   = 2'b00;
    unique case (state_q)
      ST_BUS_FREE: begin
        if (eligible[0]) begin
          start[0] = 1'b1;
          state_d  = ST_XFER0;
        end else if (eligible[1]) begin
          start[1] = 1'b1;
          state_d  = ST_XFER1;
        end
      end
      ST_XFER0, ST_XFER1: begin
        if (xfer_done) state_d = ST_BUS_OWED;
      end
      ST_BUS_OWED: begin
        if (cpu_done) state_d = ST_BUS_FREE;
      end
      default: state_d = ST_BUS_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_BUS_FREE;
    else        state_q <= state_d;
  end

  assign gnt_dma0 = (state_q == ST_XFER0);
  assign gnt_dma1 = (state_q == ST_XFER1);
  assign gnt_cpu  = (state_q == ST_BUS_FREE) || (state_q == ST_BUS_OWED);

  // R8
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({gnt_cpu, gnt_dma0, gnt_dma1}));

  // R5
  back_to_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_dma0 || gnt_dma1) && xfer_done) |=> gnt_cpu);

  // R6
  cpu_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUS_OWED && !cpu_done) |=> gnt_cpu);

  // R4
  prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUS_FREE && eligible[0]) |=> gnt_dma0);

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
  parameter int SYNC_STAGES  = 2,
  parameter int RESET_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ch_en,
  input  logic [1:0] ext_sel,
  input  logic [1:0] int_req,
  input  logic [1:0] ext_pin,
  input  logic       xfer_done,
  input  logic       cpu_done,
  output logic       gnt_cpu,
  output logic       gnt_dma0,
  output logic       gnt_dma1,
  output logic [1:0] req_pend
);

  localparam int NCH = 2;

  logic           rst_int_n;
  logic [NCH-1:0] pend;
  logic [NCH-1:0] start;
  logic [NCH-1:0] eligible;

  dma_rst_sync #(.STAGES(RESET_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    dma_req_capture #(.SYNC_STAGES(SYNC_STAGES)) u_capture (
      .clk         (clk),
      .rst_n       (rst_int_n),
      .use_ext     (ext_sel[ch]),
      .int_pulse   (int_req[ch]),
      .pin         (ext_pin[ch]),
      .grant_start (start[ch]),
      .req_o       (pend[ch])
    );
  end

  assign eligible = pend & ch_en;

  dma_bus_sequencer u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .eligible  (eligible),
    .xfer_done (xfer_done),
    .cpu_done  (cpu_done),
    .start     (start),
    .gnt_cpu   (gnt_cpu),
    .gnt_dma0  (gnt_dma0),
    .gnt_dma1  (gnt_dma1)
  );

  assign req_pend = pend;

  // R7
  dis_ch0_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (gnt_cpu && !ch_en[0]) |=> !gnt_dma0);

  // R7
  dis_ch1_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (gnt_cpu && !ch_en[1]) |=> !gnt_dma1);

  // R3
  dual_set_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ext_sel == 2'b00 && int_req == 2'b11) |=> (req_pend[1] && (req_pend[0] || gnt_dma0)));

endmodule

// File: tb/dma_req_arbiter_tb.sv
module dma_req_arbiter_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] ch_en, ext_sel, int_req, ext_pin;
  logic       xfer_done, cpu_done;
  logic       gnt_cpu, gnt_dma0, gnt_dma1;
  logic [1:0] req_pend;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_req_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .ext_sel(ext_sel),
    .int_req(int_req), .ext_pin(ext_pin), .xfer_done(xfer_done),
    .cpu_done(cpu_done), .gnt_cpu(gnt_cpu), .gnt_dma0(gnt_dma0),
    .gnt_dma1(gnt_dma1), .req_pend(req_pend)
  );

  // Vector: {en[1:0], ireq[1:0], xd, cd, exp_req[1:0], exp_own[1:0]}
  // exp_own: 0 = CPU, 1 = channel 0, 2 = channel 1
  localparam int NVEC = 19;
  localparam logic [9:0] VEC [NVEC] = '{
    10'b00_11_0_0_11_00, // R3 both set together, R7 disabled
    10'b00_00_0_0_11_00, // R7 held pending
    10'b11_00_0_0_10_01, // R4 ch0 first, R2 clear on grant
    10'b11_01_0_0_11_01, // R9 re-request during own transfer
    10'b11_00_1_0_11_00, // R5 back to CPU
    10'b11_00_0_0_11_00, // R6 wait for CPU access
    10'b11_00_0_1_11_00, // R6 CPU access done
    10'b11_00_0_0_10_01, // R9 ch0 served again, R4
    10'b11_00_1_0_10_00, // R5
    10'b11_00_0_1_10_00, // R6
    10'b11_00_0_0_00_10, // R2 ch1 granted
    10'b11_00_1_0_00_00, // R5
    10'b11_00_0_1_00_00, // R6
    10'b11_00_0_0_00_00, // R8 CPU default
    10'b01_10_0_0_10_00, // R7 ch1 disabled
    10'b01_00_0_0_10_00, // R7 still held
    10'b10_00_0_0_00_10, // R7 served once enabled
    10'b10_00_1_0_00_00, // R5
    10'b10_00_0_1_00_00  // R6
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] own_to_gnt(logic [1:0] own);
    case (own)
      2'd1:    return 3'b010;
      2'd2:    return 3'b001;
      default: return 3'b100;
    endcase
  endfunction

  task automatic pulse_clear();
    int_req   = 2'b00;
    xfer_done = 1'b0;
    cpu_done  = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ch_en = 2'b00; ext_sel = 2'b00; int_req = 2'b00;
    ext_pin = 2'b11; xfer_done = 1'b0; cpu_done = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    // R10 reset state
    check("R10 reset grants", {gnt_cpu, gnt_dma0, gnt_dma1}, 3'b100);
    check("R10 reset flags", req_pend, 2'b00);

    for (int i = 0; i < NVEC; i++) begin
      ch_en     = VEC[i][9:8];
      int_req   = VEC[i][7:6];
      xfer_done = VEC[i][5];
      cpu_done  = VEC[i][4];
      tick();
      pulse_clear();
      check($sformatf("R8 vec%0d grants", i), {gnt_cpu, gnt_dma0, gnt_dma1},
            own_to_gnt(VEC[i][1:0]));
      check($sformatf("R1 vec%0d flags", i), req_pend, VEC[i][3:2]);
    end

    // R11: internal pulse ignored when pin source selected
    ch_en = 2'b00; ext_sel = 2'b01;
    int_req = 2'b01; tick(); pulse_clear();
    tick();
    check("R11 internal ignored", req_pend, 2'b00);

    // R1: falling pin edge sets flag on third edge
    ext_pin[0] = 1'b0;
    tick(); tick();
    check("R1 pin not yet", req_pend, 2'b00);
    tick();
    check("R1 pin fall sets", req_pend, 2'b01);

    // Serve it, then confirm held-low pin does not set again
    ch_en = 2'b01;
    tick();
    check("R2 ext grant", {gnt_cpu, gnt_dma0, gnt_dma1}, 3'b010);
    check("R2 ext cleared", req_pend, 2'b00);
    xfer_done = 1'b1; tick(); pulse_clear();
    cpu_done = 1'b1; tick(); pulse_clear();
    repeat (4) tick();
    check("R1 held low once", {req_pend, gnt_cpu}, 3'b001);
    ext_pin[0] = 1'b1;
    repeat (5) tick();
    check("R1 rising ignored", {req_pend, gnt_cpu}, 3'b001);

    // R11: pin ignored when internal source selected
    ch_en = 2'b00; ext_sel = 2'b00;
    ext_pin[1] = 1'b0;
    repeat (5) tick();
    check("R11 pin ignored", req_pend, 2'b00);
    ext_pin[1] = 1'b1;
    repeat (4) tick();

    // R3 with both pins falling together
    ext_sel = 2'b11;
    ext_pin = 2'b00;
    repeat (3) tick();
    check("R3 both pins", req_pend, 2'b11);
    ext_pin = 2'b11;
    ext_sel = 2'b00;
    repeat (4) tick();

    // R10: reset in the middle of a transfer
    ch_en = 2'b01;
    tick();
    check("R4 pre-reset grant", {gnt_cpu, gnt_dma0, gnt_dma1}, 3'b010);
    rst_n = 1'b0;
    #1;
    check("R10 async grant", {gnt_cpu, gnt_dma0, gnt_dma1}, 3'b100);
    check("R10 async flags", req_pend, 2'b00);
    tick();
    rst_n = 1'b1;
    repeat (3) tick();
    check("R10 after release", {gnt_cpu, gnt_dma0, gnt_dma1}, 3'b100);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule